// File: doc/BRIEF.md
# Descriptor-Table Register Store Unit

This unit carries out the "store descriptor-table register" operation of a processor back end. The caller presents the current contents of the table register: a 16-bit limit and a 64-bit base. It also presents the operating mode, the current privilege level (CPL) and a set of condition flags. The unit captures all of these when it sees a one-cycle start pulse. It then checks privilege, prefix, address-form and alignment rules. If any rule trips, it reports exactly one fault code and writes nothing.

When every check passes, the unit streams the register image into memory through a byte-write port. It issues one byte per cycle at ascending addresses, starting at the effective address. The stream is 10 bytes long in 64-bit mode and 6 bytes long in every other mode. A one-cycle done strobe marks the end of each operation, whether it wrote bytes or faulted.

Top module: `dtr_store_unit`

## Requirements
- R1: After synchronous reset, wr_en, done, fault_valid are 0 and fault_code is 0 (none).
- R2: In 64-bit mode (op_mode=3) with no fault, 10 bytes are written one per cycle in consecutive cycles, starting the cycle after start, at eff_addr+0 to eff_addr+9. Bytes 0–1 hold the limit, least significant byte first. Bytes 2–9 hold the 64-bit base, least significant byte first.
- R3: In real (0), protected or compatibility (1), and virtual-8086 (2) modes with no fault, 6 bytes are written: the limit in bytes 0–1 and base bits 31:0 in bytes 2–5, least significant byte first.
- R4: done is high for exactly one cycle, in the cycle after the last byte. Inputs are sampled only on a start that arrives while idle. A start during a write, and any input changes during a write, do not alter the stream.
- R5: lock_pfx=1 gives fault code 1 (invalid opcode) in every mode.
- R6: With umip_en=1, modes 1 and 3 give fault code 2 (general protection) when cpl>0. Mode 2 gives fault code 2 at any cpl. Mode 0 never gives this fault.
- R7: In mode 3, an eff_addr whose bits 63:47 are not all equal gives fault code 2, or fault code 3 (stack) when use_stack=1.
- R8: In modes 0–2, lim_viol=1 gives fault code 2, or fault code 3 when use_stack=1. In mode 3, lim_viol has no effect.
- R9: With ac_en=1 and eff_addr[0]=1, fault code 4 (alignment) is raised in modes 1 and 3 only at cpl=3. In mode 2 it is raised at any cpl. In mode 0 it is never raised.
- R10: Only the highest-priority fault is reported, in this order: lock, then privilege, then address form or limit, then alignment. A fault asserts done and fault_valid for one cycle, the cycle after start, with no byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to store the register |
| op_mode | input | 2 | 0 real, 1 protected/compatibility, 2 virtual-8086, 3 64-bit |
| cpl | input | 2 | Current privilege level |
| umip_en | input | 1 | User-mode store prevention enable |
| lock_pfx | input | 1 | Lock prefix present |
| ac_en | input | 1 | Alignment checking enabled |
| use_stack | input | 1 | Destination accessed through the stack segment |
| lim_viol | input | 1 | Segment-limit violation detected upstream |
| eff_addr | input | 64 | Effective destination address |
| tbl_limit | input | 16 | Table register limit |
| tbl_base | input | 64 | Table register base |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 64 | Byte write address |
| wr_data | output | 8 | Byte write data |
| done | output | 1 | Operation finished (one cycle) |
| fault_valid | output | 1 | A fault ended the operation |
| fault_code | output | 3 | 0 none, 1 invalid opcode, 2 general protection, 3 stack, 4 alignment |

## Verification
The bench sweeps every combination of mode, privilege level, prevention enable, lock flag, alignment enable, stack flag and limit flag. Each combination is run against four destination addresses: aligned canonical, odd canonical, aligned canonical in the upper half, and non-canonical. The odd and non-canonical addresses separate the alignment and address-form rules, and overlapping flags expose the fault priority. Each passing combination is checked byte by byte with a fresh limit and base. A wrong byte order, the wrong length for a mode, or an address step error shows up as a data or address mismatch. A directed run then pulses start again during a write, together with a raised lock flag and a changed base, to show that the stream is unaffected.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
    localparam int LIMIT_W      = 16;
    localparam int BASE_W       = 64;
    localparam int ADDR_W       = 64;
    localparam int LEGACY_BASE  = 32;
    localparam int CANON_LSB    = 47;
    localparam int IMG_W        = LIMIT_W + BASE_W;
    localparam int LONG_BYTES   = IMG_W / 8;
    localparam int SHORT_BYTES  = (LIMIT_W + LEGACY_BASE) / 8;
    localparam int CNT_W        = $clog2(LONG_BYTES + 1);

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_PROT = 2'd1,
        MODE_V86  = 2'd2,
        MODE_LONG = 2'd3
    } op_mode_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_UD   = 3'd1,
        FLT_GP   = 3'd2,
        FLT_SS   = 3'd3,
        FLT_AC   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WRITE,
        SQ_DONE,
        SQ_FAULT
    } seq_state_e;

    typedef struct packed {
        logic [BASE_W-1:0]  base;
        logic [LIMIT_W-1:0] limit;
    } tbl_img_t;

    function automatic logic is_canonical(input logic [ADDR_W-1:0] a);
        return (&a[ADDR_W-1:CANON_LSB]) || !(|a[ADDR_W-1:CANON_LSB]);
    endfunction
endpackage

// File: rtl/dtr_fault_check.sv
module dtr_fault_check
    import dtr_pkg::*;
(
    input  op_mode_e          mode,
    input  logic [1:0]        cpl,
    input  logic              umip_en,
    input  logic              lock_pfx,
    input  logic              ac_en,
    input  logic              use_stack,
    input  logic              lim_viol,
    input  logic [ADDR_W-1:0] eff_addr,
    output fault_e            fault
);
    logic ring_checked;
    logic priv_hit;
    logic addr_hit;
    logic align_hit;

    always_comb begin
        ring_checked = (mode == MODE_PROT) || (mode == MODE_LONG);
        priv_hit     = umip_en && ((ring_checked && cpl != 2'd0) || mode == MODE_V86);
        addr_hit     = (mode == MODE_LONG) ? !is_canonical(eff_addr) : lim_viol;
        align_hit    = ac_en && eff_addr[0] &&
                       ((ring_checked && cpl == 2'd3) || mode == MODE_V86);
        if (lock_pfx)       fault = FLT_UD;
        else if (priv_hit)  fault = FLT_GP;
        else if (addr_hit)  fault = use_stack ? FLT_SS : FLT_GP;
        else if (align_hit) fault = FLT_AC;
        else                fault = FLT_NONE;
    end
endmodule

// File: rtl/dtr_byte_seq.sv
module dtr_byte_seq
    import dtr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  fault_e            fault_in,
    input  tbl_img_t          img_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              long_mode,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              done_o,
    output logic              fault_o,
    output fault_e            code_o,
    output logic              busy_o
);
    seq_state_e        st_q;
    tbl_img_t          img_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  last_q;
    fault_e            code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            img_q  <= '0;
            addr_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
            code_q <= FLT_NONE;
        end else begin
            case (st_q)
                SQ_IDLE: if (launch) begin
                    img_q  <= img_in;
                    addr_q <= addr_in;
                    idx_q  <= '0;
                    last_q <= long_mode ? CNT_W'(LONG_BYTES - 1) : CNT_W'(SHORT_BYTES - 1);
                    code_q <= fault_in;
                    st_q   <= (fault_in != FLT_NONE) ? SQ_FAULT : SQ_WRITE;
                end
                SQ_WRITE: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == last_q) st_q <= SQ_DONE;
                end
                default: begin
                    code_q <= FLT_NONE;
                    st_q   <= SQ_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        wr_en_o   = (st_q == SQ_WRITE);
        wr_addr_o = addr_q + ADDR_W'(idx_q);
        wr_data_o = img_q[{idx_q, 3'b000} +: 8];
        done_o    = (st_q == SQ_DONE) || (st_q == SQ_FAULT);
        fault_o   = (st_q == SQ_FAULT);
        code_o    = (st_q == SQ_FAULT) ? code_q : FLT_NONE;
        busy_o    = (st_q != SQ_IDLE);
    end

    // R10
    fault_silent_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> !wr_en_o);
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 1'b1));
    // R4
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !fault_o) |-> $past(wr_en_o));
endmodule

// File: rtl/dtr_store_unit.sv
module dtr_store_unit
    import dtr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [1:0]         op_mode,
    input  logic [1:0]         cpl,
    input  logic               umip_en,
    input  logic               lock_pfx,
    input  logic               ac_en,
    input  logic               use_stack,
    input  logic               lim_viol,
    input  logic [63:0]        eff_addr,
    input  logic [15:0]        tbl_limit,
    input  logic [63:0]        tbl_base,
    output logic               wr_en,
    output logic [63:0]        wr_addr,
    output logic [7:0]         wr_data,
    output logic               done,
    output logic               fault_valid,
    output logic [2:0]         fault_code
);
    op_mode_e mode;
    fault_e   fault_now;
    fault_e   code_out;
    tbl_img_t img;
    logic     busy;
    logic     launch;

    assign mode   = op_mode_e'(op_mode);
    assign img    = '{base: tbl_base, limit: tbl_limit};
    assign launch = start && !busy;

    dtr_fault_check u_chk (
        .mode      (mode),
        .cpl       (cpl),
        .umip_en   (umip_en),
        .lock_pfx  (lock_pfx),
        .ac_en     (ac_en),
        .use_stack (use_stack),
        .lim_viol  (lim_viol),
        .eff_addr  (eff_addr),
        .fault     (fault_now)
    );

    dtr_byte_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .fault_in  (fault_now),
        .img_in    (img),
        .addr_in   (eff_addr),
        .long_mode (mode == MODE_LONG),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .done_o    (done),
        .fault_o   (fault_valid),
        .code_o    (code_out),
        .busy_o    (busy)
    );

    assign fault_code = code_out;

    // R5
    lock_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && lock_pfx) |=> (fault_valid && fault_code == 3'd1));
    // R10
    fault_timing_chk: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (done && $past(start)));
    // R1
    code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !fault_valid |-> (fault_code == 3'd0));
endmodule

// File: tb/dtr_store_unit_bench.sv
module dtr_store_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_mode = '0;
    logic [1:0]  cpl = '0;
    logic        umip_en = 1'b0;
    logic        lock_pfx = 1'b0;
    logic        ac_en = 1'b0;
    logic        use_stack = 1'b0;
    logic        lim_viol = 1'b0;
    logic [63:0] eff_addr = '0;
    logic [15:0] tbl_limit = '0;
    logic [63:0] tbl_base = '0;
    logic        wr_en;
    logic [63:0] wr_addr;
    logic [7:0]  wr_data;
    logic        done;
    logic        fault_valid;
    logic [2:0]  fault_code;

    int chk_cnt = 0;
    int fail_cnt = 0;

    always #10 clk = ~clk;

    dtr_store_unit u_dtr_store_unit (
        .clk(clk), .rst(rst), .start(start), .op_mode(op_mode), .cpl(cpl),
        .umip_en(umip_en), .lock_pfx(lock_pfx), .ac_en(ac_en),
        .use_stack(use_stack), .lim_viol(lim_viol), .eff_addr(eff_addr),
        .tbl_limit(tbl_limit), .tbl_base(tbl_base), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
        .fault_valid(fault_valid), .fault_code(fault_code)
    );

    task automatic check(input logic ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected fault from the priority rules (R5 > R6 > R7/R8 > R9)
    function automatic logic [2:0] exp_fault(input logic [1:0] m, input logic [1:0] c,
        input logic u, input logic lk, input logic ac, input logic stk, input logic lv,
        input logic [63:0] ea);
        logic canon;
        canon = (ea[63:47] == 17'h1FFFF) || (ea[63:47] == 17'h0);
        if (lk) return 3'd1;
        if (u && (((m == 2'd1 || m == 2'd3) && c != 2'd0) || m == 2'd2)) return 3'd2;
        if (m == 2'd3 && !canon) return stk ? 3'd3 : 3'd2;
        if (m != 2'd3 && lv) return stk ? 3'd3 : 3'd2;
        if (ac && ea[0] && (((m == 2'd1 || m == 2'd3) && c == 2'd3) || m == 2'd2)) return 3'd4;
        return 3'd0;
    endfunction

    function automatic string fault_tag(input logic [1:0] m, input logic [1:0] c,
        input logic u, input logic lk, input logic [63:0] ea);
        if (lk) return "R5 lock";
        if (u && (((m == 2'd1 || m == 2'd3) && c != 2'd0) || m == 2'd2)) return "R6 prevention";
        if (m == 2'd3 && !((ea[63:47] == 17'h1FFFF) || (ea[63:47] == 17'h0))) return "R7 canonical";
        if (m != 2'd3) return "R8/R9 limit-or-align";
        return "R9 align";
    endfunction

    task automatic run_op(input logic [1:0] m, input logic [1:0] c, input logic u,
        input logic lk, input logic ac, input logic stk, input logic lv,
        input logic [63:0] ea, input logic [15:0] lim, input logic [63:0] bs, input int poke);
        logic [2:0]  ef;
        logic [79:0] img;
        int          len;
        string       tag;
        ef  = exp_fault(m, c, u, lk, ac, stk, lv, ea);
        len = (m == 2'd3) ? 10 : 6;
        img = {bs, lim};
        tag = (m == 2'd3) ? "R2 byte" : "R3 byte";
        op_mode = m; cpl = c; umip_en = u; lock_pfx = lk; ac_en = ac;
        use_stack = stk; lim_viol = lv; eff_addr = ea; tbl_limit = lim; tbl_base = bs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (ef != 3'd0) begin
            check(fault_valid && done && !wr_en && fault_code == ef,
                  {fault_tag(m, c, u, lk, ea), " R10 fault"},
                  {75'(fault_code), fault_valid, done, wr_en, 1'b0},
                  {75'(ef), 1'b1, 1'b1, 1'b0, 1'b0});
            @(negedge clk);
            check(!done && !fault_valid && !wr_en, "R10 single cycle",
                  {77'b0, done, fault_valid, wr_en}, 80'b0);
        end else begin
            for (int k = 0; k < len; k++) begin
                check(wr_en && !done && wr_addr == ea + 64'(k) && wr_data == img[8*k +: 8],
                      tag, {wr_addr, wr_data, 6'b0, wr_en, done},
                      {ea + 64'(k), img[8*k +: 8], 6'b0, 1'b1, 1'b0});
                if (k == poke) begin
                    start = 1'b1; lock_pfx = 1'b1; tbl_base = ~bs; eff_addr = ~ea;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
            end
            start = 1'b0;
            check(done && !fault_valid && !wr_en, "R4 done",
                  {77'b0, done, fault_valid, wr_en}, {77'b0, 3'b100});
            @(negedge clk);
            check(!done && !wr_en && !fault_valid, "R4 idle after done",
                  {77'b0, done, fault_valid, wr_en}, 80'b0);
        end
    endtask

    initial begin
        logic [63:0] addrs [4];
        int          n;
        addrs[0] = 64'h0000_1234_5678_9ABC;
        addrs[1] = 64'h0000_1234_5678_9ABD;
        addrs[2] = 64'h0001_0000_0000_0010;
        addrs[3] = 64'hFFFF_8000_0000_0002;
        n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!wr_en && !done && !fault_valid && fault_code == 3'd0, "R1 reset",
              {74'b0, fault_code, wr_en, done, fault_valid}, 80'b0);
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 4; c++)
                for (int f = 0; f < 32; f++)
                    for (int a = 0; a < 4; a++) begin
                        n++;
                        run_op(2'(m), 2'(c), f[0], f[1], f[2], f[3], f[4], addrs[a],
                               16'(n * 40503), {32'(n) * 32'h9E3779B9, ~(32'(n) * 32'h85EBCA6B)}, -1);
                    end
        // R4: second start during a write, with changed inputs, is ignored
        run_op(2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_1000,
               16'hBEEF, 64'h0102_0304_0506_0708, 3);
        run_op(2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_2000,
               16'h1357, 64'hCAFE_F00D_DEAD_BEEF, 2);
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk_cnt++;
        fail_cnt++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    end
endmodule